// File: doc/BRIEF.md
# Dual-Axis Counter Host Port

This block is the byte-wide host bus front end of a two-axis position counter. A host drives chip select, read and write strobes (all active low), a control/data select, an axis select and an 8-bit data byte. The block runs in its own system clock domain. It synchronizes the strobes and detects each completed access from the synchronized strobe edge. Each access then goes to the right per-axis register.

Control writes use the top three bits of the byte. Bits 6:5 pick one of four per-axis registers. Bit 7 sends the write to both axes at once, overriding the axis pin. Three of those registers hold configuration fields for the counter core. The fourth is a command register, which the block turns into one-cycle strobes and internal actions. Data writes fill a 24-bit preset value one byte at a time. Data reads return a 24-bit output latch one byte at a time. A per-axis byte pointer steps through the bytes, low byte first, after every data access. Control reads return the flag byte that the core supplies for the selected axis.

Top module: `qc_host_port`

## Requirements
- R1: On a control write (cd = 1), byte bits 6:5 select the target: 00 command, 01 count-mode, 10 I/O-control, 11 index-control. For the last three, bits 4:0 are stored and appear on `cfg_mode`, `cfg_io` or `cfg_idx`.
- R2: Control byte bit 7 = 1 writes the selected register of both axes. Bit 7 = 0 writes only the axis given by `axis_sel` (0 = X = index 0, 1 = Y = index 1).
- R3: While `cs_n` is high, strobe pulses change no register, pointer or strobe output, and `dout_oe` stays low.
- R4: A write takes effect only after the trailing (rising) edge of the low write pulse. `dout_oe` is high only while both `rd_n` and `cs_n` are low, and `dout` is zero otherwise.
- R5: A data write (cd = 0) stores the byte into the preset byte at the axis's byte pointer (0 = bits 7:0, 1 = 15:8, 2 = 23:16), shown on `preset`.
- R6: Each data read or write advances that axis's byte pointer by exactly one, wrapping from 2 to 0. Control accesses and the other axis's pointer are unaffected.
- R7: A data read returns the output-latch byte at the axis's byte pointer. A control read returns `flag_val` of the selected axis and leaves the pointer unchanged.
- R8: Command byte bit 0 = 1 resets the byte pointer to 0.
- R9: Command bits 2:1 give a one-cycle pulse: 01 `stb_rst_cnt`, 10 `stb_clr_tgl`, 11 `stb_clr_err`.
- R10: Command bits 4:3: 01 pulses `stb_ld_cnt`, 10 copies all 24 bits of `cnt_val` into the output latch at once, 11 pulses `stb_ld_psc`. The latch then holds its value until the next such command.
- R11: After reset, all registers, presets, latches and pointers are zero, no strobe is active and `dout_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| cd | input | 1 | 1 = control, 0 = data |
| axis_sel | input | 1 | 0 = X, 1 = Y |
| din | input | 8 | Write data byte |
| dout | output | 8 | Read data byte |
| dout_oe | output | 1 | Read data drive enable |
| cnt_val | input | 2x24 | Live counter value per axis |
| flag_val | input | 2x8 | Flag byte per axis |
| preset | output | 2x24 | Preset value per axis |
| cfg_mode | output | 2x5 | Count-mode field per axis |
| cfg_io | output | 2x5 | I/O-control field per axis |
| cfg_idx | output | 2x5 | Index-control field per axis |
| stb_rst_cnt | output | 2 | Reset-counter pulse per axis |
| stb_clr_tgl | output | 2 | Clear toggles/sign pulse per axis |
| stb_clr_err | output | 2 | Clear error flag pulse per axis |
| stb_ld_cnt | output | 2 | Preset-to-counter pulse per axis |
| stb_ld_psc | output | 2 | Preset low byte to prescaler pulse per axis |

## Verification
A single command byte can reset the byte pointer and copy the counter into the output latch in the same cycle. The bench sends 0x11 after a partial read has left the pointer away from byte 0. The next reads must return the fresh value starting at its low byte. Commands that combine a clear strobe with a transfer strobe (for example 0x0E), and broadcast commands that hit both axes together, are judged by comparing per-axis pulse counts with the counts a bench model predicts.

// File: rtl/qc_host_pkg.sv
package qc_host_pkg;
    localparam int BYTE_W = 8;
    localparam int NBYTES = 3;
    localparam int WORD_W = BYTE_W * NBYTES;
    localparam int AXES   = 2;
    localparam int CFG_W  = 5;
    localparam int BP_W   = $clog2(NBYTES);

    typedef enum logic [1:0] {
        SEL_CMD  = 2'b00,
        SEL_MODE = 2'b01,
        SEL_IO   = 2'b10,
        SEL_IDX  = 2'b11
    } ctl_sel_e;

    typedef struct packed {
        logic [1:0] xfer_op;
        logic [1:0] clr_op;
        logic       bp_clr;
    } cmd_t;

    typedef struct packed {
        logic rst_cnt;
        logic clr_tgl;
        logic clr_err;
        logic ld_cnt;
        logic ld_psc;
    } strobe_t;

    function automatic cmd_t decode_cmd(input logic [BYTE_W-1:0] b);
        cmd_t c;
        c.bp_clr  = b[0];
        c.clr_op  = b[2:1];
        c.xfer_op = b[4:3];
        return c;
    endfunction

    function automatic logic [BP_W-1:0] next_bp(input logic [BP_W-1:0] bp);
        return (bp == BP_W'(NBYTES - 1)) ? '0 : BP_W'(bp + 1'b1);
    endfunction
endpackage

// File: rtl/qc_sync.sv
module qc_sync #(
    parameter int            W       = 1,
    parameter int            STAGES  = 2,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= {STAGES{RST_VAL}};
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/qc_axis_regs.sv
module qc_axis_regs
    import qc_host_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ctl_wr,
    input  logic                 dat_wr,
    input  logic                 dat_rd,
    input  logic [BYTE_W-1:0]    wbyte,
    input  logic [WORD_W-1:0]    cnt_val,
    output logic [WORD_W-1:0]    preset,
    output logic [CFG_W-1:0]     cfg_mode,
    output logic [CFG_W-1:0]     cfg_io,
    output logic [CFG_W-1:0]     cfg_idx,
    output strobe_t              stb,
    output logic [BYTE_W-1:0]    ol_byte
);
    logic [BP_W-1:0]                 bp;
    logic [NBYTES-1:0][BYTE_W-1:0]   pre_q;
    logic [NBYTES-1:0][BYTE_W-1:0]   ol_q;
    cmd_t                            cmd;
    ctl_sel_e                        sel;

    assign cmd = decode_cmd(wbyte);
    assign sel = ctl_sel_e'(wbyte[6:5]);

    always_ff @(posedge clk) begin
        if (rst) begin
            bp       <= '0;
            pre_q    <= '0;
            ol_q     <= '0;
            cfg_mode <= '0;
            cfg_io   <= '0;
            cfg_idx  <= '0;
            stb      <= '0;
        end else begin
            stb <= '0;
            if (ctl_wr) begin
                unique case (sel)
                    SEL_CMD: begin
                        if (cmd.bp_clr) bp <= '0;
                        unique case (cmd.clr_op)
                            2'b01:   stb.rst_cnt <= 1'b1;
                            2'b10:   stb.clr_tgl <= 1'b1;
                            2'b11:   stb.clr_err <= 1'b1;
                            default: ;
                        endcase
                        unique case (cmd.xfer_op)
                            2'b01:   stb.ld_cnt <= 1'b1;
                            2'b10:   ol_q       <= cnt_val;
                            2'b11:   stb.ld_psc <= 1'b1;
                            default: ;
                        endcase
                    end
                    SEL_MODE: cfg_mode <= wbyte[CFG_W-1:0];
                    SEL_IO:   cfg_io   <= wbyte[CFG_W-1:0];
                    SEL_IDX:  cfg_idx  <= wbyte[CFG_W-1:0];
                endcase
            end
            if (dat_wr) begin
                pre_q[bp] <= wbyte;
                bp        <= next_bp(bp);
            end
            if (dat_rd) bp <= next_bp(bp);
        end
    end

    assign preset  = pre_q;
    assign ol_byte = ol_q[bp];

    // R6: pointer steps by one below the top byte
    p_bp_step_r6: assert property (@(posedge clk) disable iff (rst)
        (dat_wr || dat_rd) && bp != BP_W'(NBYTES - 1) |=> bp == BP_W'($past(bp) + 1'b1));
    // R6: pointer wraps from the top byte to byte 0
    p_bp_wrap_r6: assert property (@(posedge clk) disable iff (rst)
        (dat_wr || dat_rd) && bp == BP_W'(NBYTES - 1) |=> bp == '0);
    // R8: command bit 0 clears the pointer
    p_bp_clr_r8: assert property (@(posedge clk) disable iff (rst)
        ctl_wr && wbyte[6:5] == 2'b00 && wbyte[0] |=> bp == '0);
    // R10: counter-to-latch copies the whole word
    p_ol_xfer_r10: assert property (@(posedge clk) disable iff (rst)
        ctl_wr && wbyte[6:5] == 2'b00 && wbyte[4:3] == 2'b10 |=> ol_q == $past(cnt_val));
    // R5: a data write lands in the pointed preset byte
    p_pre_write_r5: assert property (@(posedge clk) disable iff (rst)
        dat_wr |=> pre_q[$past(bp)] == $past(wbyte));
endmodule

// File: rtl/qc_host_port.sv
module qc_host_port
    import qc_host_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cs_n,
    input  logic                          rd_n,
    input  logic                          wr_n,
    input  logic                          cd,
    input  logic                          axis_sel,
    input  logic [7:0]                    din,
    output logic [7:0]                    dout,
    output logic                          dout_oe,
    input  logic [1:0][23:0]              cnt_val,
    input  logic [1:0][7:0]               flag_val,
    output logic [1:0][23:0]              preset,
    output logic [1:0][4:0]               cfg_mode,
    output logic [1:0][4:0]               cfg_io,
    output logic [1:0][4:0]               cfg_idx,
    output logic [1:0]                    stb_rst_cnt,
    output logic [1:0]                    stb_clr_tgl,
    output logic [1:0]                    stb_clr_err,
    output logic [1:0]                    stb_ld_cnt,
    output logic [1:0]                    stb_ld_psc
);
    localparam int BUS_W = BYTE_W + 2;

    logic              cs_s, rd_s, wr_s;
    logic [BUS_W-1:0]  bus_s;
    logic              cd_s, ysel_s;
    logic [BYTE_W-1:0] din_s;

    qc_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_sync_ctl (
        .clk(clk), .rst(rst), .d({cs_n, rd_n, wr_n}), .q({cs_s, rd_s, wr_s}));
    qc_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_bus (
        .clk(clk), .rst(rst), .d({cd, axis_sel, din}), .q(bus_s));

    assign {cd_s, ysel_s, din_s} = bus_s;

    logic              wr_act, rd_act, wr_act_q, rd_act_q;
    logic              wr_done, rd_done;
    logic              snap_cd, snap_ysel;
    logic [BYTE_W-1:0] snap_din;

    assign wr_act = ~cs_s & ~wr_s;
    assign rd_act = ~cs_s & ~rd_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_act_q  <= 1'b0;
            rd_act_q  <= 1'b0;
            snap_cd   <= 1'b0;
            snap_ysel <= 1'b0;
            snap_din  <= '0;
        end else begin
            wr_act_q <= wr_act;
            rd_act_q <= rd_act;
            if (wr_act || rd_act) begin
                snap_cd   <= cd_s;
                snap_ysel <= ysel_s;
                snap_din  <= din_s;
            end
        end
    end

    assign wr_done = wr_act_q & ~wr_act;
    assign rd_done = rd_act_q & ~rd_act;

    logic [AXES-1:0][BYTE_W-1:0] ol_byte;

    for (genvar a = 0; a < AXES; a++) begin : g_axis
        logic    hit_axis;
        strobe_t stb;

        assign hit_axis = (snap_ysel == 1'(a));

        qc_axis_regs u_axis (
            .clk      (clk),
            .rst      (rst),
            .ctl_wr   (wr_done & snap_cd & (snap_din[7] | hit_axis)),
            .dat_wr   (wr_done & ~snap_cd & hit_axis),
            .dat_rd   (rd_done & ~snap_cd & hit_axis),
            .wbyte    (snap_din),
            .cnt_val  (cnt_val[a]),
            .preset   (preset[a]),
            .cfg_mode (cfg_mode[a]),
            .cfg_io   (cfg_io[a]),
            .cfg_idx  (cfg_idx[a]),
            .stb      (stb),
            .ol_byte  (ol_byte[a])
        );

        assign stb_rst_cnt[a] = stb.rst_cnt;
        assign stb_clr_tgl[a] = stb.clr_tgl;
        assign stb_clr_err[a] = stb.clr_err;
        assign stb_ld_cnt[a]  = stb.ld_cnt;
        assign stb_ld_psc[a]  = stb.ld_psc;
    end

    assign dout_oe = rd_act;
    assign dout    = !rd_act ? '0 : (cd_s ? flag_val[ysel_s] : ol_byte[ysel_s]);

    if (SYNC_STAGES == 2) begin : g_chk
        // R4: output drive only follows a low read and low select
        p_oe_needs_rd_r4: assert property (@(posedge clk) disable iff (rst)
            dout_oe |-> !$past(rd_n, 2) && !$past(cs_n, 2));
        // R3: a long deselect leaves no strobe and no drive
        p_quiet_r3: assert property (@(posedge clk) disable iff (rst)
            cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3) && $past(cs_n, 4)
            |-> !dout_oe && (stb_rst_cnt | stb_clr_tgl | stb_clr_err | stb_ld_cnt | stb_ld_psc) == 2'b00);
    end
endmodule

// File: tb/test_qc_host_port.sv
module test_qc_host_port;
    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, cd = 1'b0, axis_sel = 1'b0;
    logic [7:0]        din = '0;
    logic [7:0]        dout;
    logic              dout_oe;
    logic [1:0][23:0]  cnt_val = '0;
    logic [1:0][7:0]   flag_val = '0;
    logic [1:0][23:0]  preset;
    logic [1:0][4:0]   cfg_mode, cfg_io, cfg_idx;
    logic [1:0]        stb_rst_cnt, stb_clr_tgl, stb_clr_err, stb_ld_cnt, stb_ld_psc;

    always #5 clk = ~clk;

    qc_host_port i_qc_host_port (.*);

    int n_tests = 0, n_fail = 0;
    bit done = 0;

    // bench model
    int          m_bp [2];
    logic [23:0] m_pre [2];
    logic [23:0] m_ol [2];
    logic [4:0]  m_mode [2], m_io [2], m_idx [2];
    int          e_cnt [5][2];
    int          s_cnt [5][2];

    always @(posedge clk) begin
        if (!rst) begin
            for (int a = 0; a < 2; a++) begin
                s_cnt[0][a] += int'(stb_rst_cnt[a]);
                s_cnt[1][a] += int'(stb_clr_tgl[a]);
                s_cnt[2][a] += int'(stb_clr_err[a]);
                s_cnt[3][a] += int'(stb_ld_cnt[a]);
                s_cnt[4][a] += int'(stb_ld_psc[a]);
            end
        end
    end

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic model_ctl(logic ys, logic [7:0] b);
        for (int a = 0; a < 2; a++) begin
            if (b[7] || ys == 1'(a)) begin
                case (b[6:5])
                    2'b00: begin
                        if (b[0]) m_bp[a] = 0;
                        if (b[2:1] != 0) e_cnt[b[2:1] - 1][a]++;
                        if (b[4:3] == 2'b01) e_cnt[3][a]++;
                        if (b[4:3] == 2'b10) m_ol[a] = cnt_val[a];
                        if (b[4:3] == 2'b11) e_cnt[4][a]++;
                    end
                    2'b01: m_mode[a] = b[4:0];
                    2'b10: m_io[a]   = b[4:0];
                    default: m_idx[a] = b[4:0];
                endcase
            end
        end
    endtask

    task automatic compare_all(string tag);
        for (int a = 0; a < 2; a++) begin
            chk("R5", {tag, " preset"}, 32'(preset[a]), 32'(m_pre[a]));
            chk("R1", {tag, " mode"}, 32'(cfg_mode[a]), 32'(m_mode[a]));
            chk("R1", {tag, " io"}, 32'(cfg_io[a]), 32'(m_io[a]));
            chk("R2", {tag, " idx"}, 32'(cfg_idx[a]), 32'(m_idx[a]));
            for (int k = 0; k < 3; k++)
                chk("R9", {tag, " clear strobe count"}, 32'(s_cnt[k][a]), 32'(e_cnt[k][a]));
            chk("R10", {tag, " ld_cnt count"}, 32'(s_cnt[3][a]), 32'(e_cnt[3][a]));
            chk("R10", {tag, " ld_psc count"}, 32'(s_cnt[4][a]), 32'(e_cnt[4][a]));
        end
    endtask

    // write pulse; sel=0 leaves cs_n high (no access)
    task automatic bus_write(logic c, logic ys, logic [7:0] b, bit sel = 1, bit check_hold = 0);
        @(negedge clk);
        cd = c; axis_sel = ys; din = b; cs_n = !sel; wr_n = 1'b0;
        repeat (4) @(negedge clk);
        if (check_hold) begin
            chk("R4", "no commit while write low mode0", 32'(cfg_mode[0]), 32'(m_mode[0]));
            chk("R4", "no commit while write low mode1", 32'(cfg_mode[1]), 32'(m_mode[1]));
        end
        wr_n = 1'b1; cs_n = 1'b1;
        repeat (6) @(negedge clk);
        if (sel) begin
            if (c) model_ctl(ys, b);
            else begin
                m_pre[ys][m_bp[ys]*8 +: 8] = b;
                m_bp[ys] = (m_bp[ys] + 1) % 3;
            end
        end
    endtask

    task automatic bus_read(logic c, logic ys, string req, bit sel = 1);
        logic [7:0] exp;
        @(negedge clk);
        cd = c; axis_sel = ys; cs_n = !sel; rd_n = 1'b0;
        repeat (4) @(negedge clk);
        if (sel) begin
            exp = c ? flag_val[ys] : m_ol[ys][m_bp[ys]*8 +: 8];
            chk("R4", "oe during read", 32'(dout_oe), 32'd1);
            chk(req, "read data", 32'(dout), 32'(exp));
        end else begin
            chk("R3", "oe with cs high", 32'(dout_oe), 32'd0);
            chk("R4", "dout zero without drive", 32'(dout), 32'd0);
        end
        rd_n = 1'b1; cs_n = 1'b1;
        repeat (6) @(negedge clk);
        chk("R4", "oe after read", 32'(dout_oe), 32'd0);
        if (sel && !c) m_bp[ys] = (m_bp[ys] + 1) % 3;
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7266));
        for (int a = 0; a < 2; a++) begin
            m_bp[a] = 0; m_pre[a] = '0; m_ol[a] = '0;
            m_mode[a] = '0; m_io[a] = '0; m_idx[a] = '0;
            for (int k = 0; k < 5; k++) begin e_cnt[k][a] = 0; s_cnt[k][a] = 0; end
        end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R11 reset state
        chk("R11", "oe after reset", 32'(dout_oe), 32'd0);
        chk("R11", "presets after reset", 32'(|preset), 32'd0);
        chk("R11", "cfg after reset", 32'(|{cfg_mode, cfg_io, cfg_idx}), 32'd0);
        compare_all("R11 reset");

        // R1/R2 axis-pin and broadcast control writes, R4 hold while low
        bus_write(1, 0, 8'h2A, 1, 1);
        compare_all("R1 mode X");
        bus_write(1, 0, 8'hC5);
        compare_all("R2 broadcast io");
        bus_write(1, 1, 8'h73);
        compare_all("R1 idx Y");

        // R3 no access with cs high
        bus_write(1, 1, 8'hBF, 0);
        bus_write(0, 0, 8'hEE, 0);
        compare_all("R3 deselected write");
        bus_read(0, 0, "R3", 0);

        // R5/R6 preset bytes low first, then wrap
        bus_write(0, 0, 8'h56);
        bus_write(0, 0, 8'h34);
        bus_write(0, 0, 8'h12);
        chk("R5", "preset X word", 32'(preset[0]), 32'h123456);
        bus_write(0, 0, 8'hAB);
        chk("R6", "wrap to byte 0", 32'(preset[0]), 32'h1234AB);
        chk("R6", "other axis preset untouched", 32'(preset[1]), 32'h0);

        // R8 pointer reset
        bus_write(1, 0, 8'h01);
        bus_write(0, 0, 8'h77);
        chk("R8", "byte 0 after pointer reset", 32'(preset[0]), 32'h123477);

        // R10 + R8 in one command, R7 reads and R6 wrap on reads
        cnt_val[0] = 24'hA1B2C3;
        bus_write(1, 0, 8'h11);
        bus_read(0, 0, "R10");
        bus_read(0, 0, "R10");
        cnt_val[0] = 24'h0F0F0F;
        bus_read(0, 0, "R10");
        bus_read(0, 0, "R6");
        // partial pointer then combined reset+latch
        bus_write(1, 0, 8'h11);
        bus_read(0, 0, "R7");

        // R7 flag read leaves pointer
        flag_val[1] = 8'h5A;
        bus_read(1, 1, "R7");
        bus_read(1, 0, "R7");
        bus_read(0, 0, "R7");

        // R9/R10 strobes, single, combined and broadcast
        bus_write(1, 0, 8'h02);
        bus_write(1, 0, 8'h84);
        bus_write(1, 1, 8'h06);
        bus_write(1, 1, 8'h08);
        bus_write(1, 0, 8'h18);
        bus_write(1, 0, 8'h0E);
        bus_write(1, 1, 8'h9E);
        compare_all("R9 strobes");

        // random phase
        for (int i = 0; i < 400; i++) begin
            int r;
            logic ys;
            r  = int'($urandom % 10);
            ys = 1'($urandom);
            if (r < 3)      bus_write(1, ys, 8'($urandom));
            else if (r < 6) bus_write(0, ys, 8'($urandom));
            else if (r < 8) bus_read(0, ys, "R7");
            else if (r < 9) bus_read(1, ys, "R7");
            else begin
                cnt_val[ys]  = 24'($urandom);
                flag_val[ys] = 8'($urandom);
            end
            compare_all("R6 random");
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule